// File: doc/BRIEF.md
# Memory-Resident Workspace Context Switcher

This block is the context engine of a small processor whose sixteen general registers are not flip-flops but sixteen consecutive words of main memory. The only hardware state is a workspace pointer, a program counter and a status word. A general register is reached by adding twice its number to the workspace pointer and issuing one access on a synchronous word-memory port. Moving the workspace pointer therefore swaps the whole register set at once.

On top of plain register reads and writes, the engine runs three multi-access sequences. A vectored call fetches a new workspace pointer and program counter from a two-word vector. It then stores the caller's pointer, counter and status into registers 13, 14 and 15 of the new workspace and switches to it. A return reads those three registers back into the hardware state. A link operation saves the current counter into register 11 and jumps to a supplied address. Two immediate commands load the hardware state directly, and the call and return sequences use that state as their starting point.

A command is issued with a one-cycle start pulse and an opcode. The engine reports `busy` while it drives the memory port.

Top module: `wsp_ctx_engine`

## Requirements
- R1: Reset (active high, synchronous) clears the workspace pointer, program counter and status to zero and leaves the engine idle with `busy` and `mem_req` low. This also applies when reset arrives in the middle of a sequence.
- R2: Opcode 0 reads register `cmd_reg` with one memory read at address WP + 2*n. The word read appears on `rd_data` with `rd_valid` high for one cycle, in the cycle after the read is accepted.
- R3: Opcode 1 writes `cmd_wdata` to register `cmd_reg` with one memory write at address WP + 2*n.
- R4: Register addresses are computed modulo 2^16, so a workspace near the top of the address space wraps to address zero.
- R5: Opcode 2 (call) reads the new WP from address `cmd_addr` and the new PC from `cmd_addr`+2. Both reads complete before the first write.
- R6: The call then writes the old WP, old PC and old ST, in that order, to new-WP+26, +28 and +30. After that, WP and PC take the fetched values and ST is unchanged. This holds even when the vector lies inside the new workspace.
- R7: Opcode 3 (return) reads WP+26, WP+28 and WP+30 in that order, issues no write, and loads WP, PC and ST from those three words.
- R8: Opcode 4 (link) writes the current PC to WP+22 and then sets PC to `cmd_addr`. WP and ST are unchanged.
- R9: For opcodes 0 to 4, `busy` rises in the cycle after the accepted start pulse and falls in the cycle after the last memory access is accepted. A start pulse while `busy` is high has no effect on memory or state.
- R10: A memory access completes only in a cycle where `mem_req` and `mem_ready` are both high. While `mem_ready` is low, the request, address, direction and write data are held.
- R11: Opcode 5 sets WP to `cmd_addr`. Opcode 6 sets PC to `cmd_addr` and ST to `cmd_wdata`. Both take effect in the cycle after the pulse, with no memory access and no `busy`.
- R12: Opcode 7 changes no state and makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Command opcode (0 read, 1 write, 2 call, 3 return, 4 link, 5 set WP, 6 set PC/ST, 7 none) |
| cmd_reg | input | 4 | General register number for read or write |
| cmd_addr | input | 16 | Vector address, link target, or value for WP/PC loads |
| cmd_wdata | input | 16 | Register write data, or ST value for opcode 6 |
| busy | output | 1 | Sequence in progress |
| rd_valid | output | 1 | Register read data valid |
| rd_data | output | 16 | Register read data |
| wp_o | output | 16 | Current workspace pointer |
| pc_o | output | 16 | Current program counter |
| st_o | output | 16 | Current status word |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory byte address (word aligned) |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid in the accepting cycle |
| mem_ready | input | 1 | Memory accepts the current access this cycle |

## Verification
The hardest case to reach is a call whose vector overlaps the new workspace. In that case the save of the old pointer overwrites the vector word that was just read. The stimulus places the vector exactly at new-WP+26, so any reordering of reads and writes either corrupts the fetched values or leaves the wrong word in memory. A second hard case is a start pulse that lands mid-sequence while the memory port is stalled. To reach it, the bench drives a pseudo-random ready pattern during a call and pulses a write command after `busy` has risen. It then confirms that the memory contents and the access log show no trace of that pulse.

// File: rtl/wsp_pkg.sv
package wsp_pkg;

    localparam int WORD_W         = 16;
    localparam int REG_CNT        = 16;
    localparam int IDX_W          = $clog2(REG_CNT);
    localparam int BYTES_PER_WORD = WORD_W / 8;
    localparam int CTX_FIELDS     = 3;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  ridx_t;

    localparam ridx_t IDX_LINK   = ridx_t'(11);
    localparam ridx_t IDX_OLD_WP = ridx_t'(13);
    localparam ridx_t IDX_OLD_PC = ridx_t'(14);
    localparam ridx_t IDX_OLD_ST = ridx_t'(15);

    typedef enum logic [2:0] {
        OP_REG_RD   = 3'd0,
        OP_REG_WR   = 3'd1,
        OP_CALL     = 3'd2,
        OP_RETURN   = 3'd3,
        OP_LINK     = 3'd4,
        OP_SET_WP   = 3'd5,
        OP_SET_PCST = 3'd6,
        OP_NONE     = 3'd7
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD,
        S_WR,
        S_VEC_WP,
        S_VEC_PC,
        S_SAVE_WP,
        S_SAVE_PC,
        S_SAVE_ST,
        S_REST_WP,
        S_REST_PC,
        S_REST_ST,
        S_LINK
    } seq_e;

    typedef struct packed {
        logic  req;
        logic  we;
        word_t addr;
        word_t wdata;
    } mem_cmd_t;

    typedef struct packed {
        word_t wp;
        word_t pc;
        word_t st;
    } ctx_t;

    typedef struct packed {
        logic wp_we;
        logic pc_we;
        logic st_we;
        ctx_t val;
    } ctx_upd_t;

    function automatic word_t reg_addr(word_t base, ridx_t idx);
        return base + (word_t'(idx) * word_t'(BYTES_PER_WORD));
    endfunction

    function automatic word_t next_word(word_t a);
        return a + word_t'(BYTES_PER_WORD);
    endfunction

    function automatic seq_e entry_state(op_e op);
        case (op)
            OP_REG_RD: return S_RD;
            OP_REG_WR: return S_WR;
            OP_CALL:   return S_VEC_WP;
            OP_RETURN: return S_REST_WP;
            OP_LINK:   return S_LINK;
            default:   return S_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/wsp_ctx_regs.sv
module wsp_ctx_regs
    import wsp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ctx_upd_t upd,
    output ctx_t     ctx
);

    word_t nxt [CTX_FIELDS];
    logic  wen [CTX_FIELDS];
    word_t cur [CTX_FIELDS];

    always_comb begin
        nxt[0] = upd.val.wp;
        nxt[1] = upd.val.pc;
        nxt[2] = upd.val.st;
        wen[0] = upd.wp_we;
        wen[1] = upd.pc_we;
        wen[2] = upd.st_we;
    end

    for (genvar f = 0; f < CTX_FIELDS; f++) begin : g_fld
        word_t r;
        always_ff @(posedge clk) begin
            if (rst)
                r <= '0;
            else if (wen[f])
                r <= nxt[f];
        end
        assign cur[f] = r;
    end

    assign ctx.wp = cur[0];
    assign ctx.pc = cur[1];
    assign ctx.st = cur[2];

    // R1: state is zero in the cycle after any reset cycle
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (ctx.wp == '0 && ctx.pc == '0 && ctx.st == '0));

endmodule

// File: rtl/wsp_sequencer.sv
module wsp_sequencer
    import wsp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  op_e      op,
    input  ridx_t    idx,
    input  word_t    addr,
    input  word_t    wdata,
    input  ctx_t     ctx,
    output mem_cmd_t mcmd,
    input  logic     mready,
    input  word_t    mrdata,
    output logic     busy,
    output word_t    rd_data,
    output logic     rd_valid,
    output ctx_upd_t upd
);

    seq_e  state_q, state_d;
    op_e   op_q;
    ridx_t idx_q;
    word_t addr_q;
    word_t data_q;
    word_t tmp_wp_q;
    word_t tmp_pc_q;

    logic launch;
    logic accept;

    assign launch = (state_q == S_IDLE) && start;
    assign accept = mcmd.req && mready;
    assign busy   = (state_q != S_IDLE);

    // memory command for the current step
    always_comb begin
        mcmd = '0;
        case (state_q)
            S_RD: begin
                mcmd.req  = 1'b1;
                mcmd.addr = reg_addr(ctx.wp, idx_q);
            end
            S_WR: begin
                mcmd.req   = 1'b1;
                mcmd.we    = 1'b1;
                mcmd.addr  = reg_addr(ctx.wp, idx_q);
                mcmd.wdata = data_q;
            end
            S_VEC_WP: begin
                mcmd.req  = 1'b1;
                mcmd.addr = addr_q;
            end
            S_VEC_PC: begin
                mcmd.req  = 1'b1;
                mcmd.addr = next_word(addr_q);
            end
            S_SAVE_WP: begin
                mcmd.req   = 1'b1;
                mcmd.we    = 1'b1;
                mcmd.addr  = reg_addr(tmp_wp_q, IDX_OLD_WP);
                mcmd.wdata = ctx.wp;
            end
            S_SAVE_PC: begin
                mcmd.req   = 1'b1;
                mcmd.we    = 1'b1;
                mcmd.addr  = reg_addr(tmp_wp_q, IDX_OLD_PC);
                mcmd.wdata = ctx.pc;
            end
            S_SAVE_ST: begin
                mcmd.req   = 1'b1;
                mcmd.we    = 1'b1;
                mcmd.addr  = reg_addr(tmp_wp_q, IDX_OLD_ST);
                mcmd.wdata = ctx.st;
            end
            S_REST_WP: begin
                mcmd.req  = 1'b1;
                mcmd.addr = reg_addr(ctx.wp, IDX_OLD_WP);
            end
            S_REST_PC: begin
                mcmd.req  = 1'b1;
                mcmd.addr = reg_addr(ctx.wp, IDX_OLD_PC);
            end
            S_REST_ST: begin
                mcmd.req  = 1'b1;
                mcmd.addr = reg_addr(ctx.wp, IDX_OLD_ST);
            end
            S_LINK: begin
                mcmd.req   = 1'b1;
                mcmd.we    = 1'b1;
                mcmd.addr  = reg_addr(ctx.wp, IDX_LINK);
                mcmd.wdata = ctx.pc;
            end
            default: mcmd = '0;
        endcase
    end

    // step order
    always_comb begin
        state_d = state_q;
        if (launch) begin
            state_d = entry_state(op);
        end else if (accept) begin
            case (state_q)
                S_VEC_WP:  state_d = S_VEC_PC;
                S_VEC_PC:  state_d = S_SAVE_WP;
                S_SAVE_WP: state_d = S_SAVE_PC;
                S_SAVE_PC: state_d = S_SAVE_ST;
                S_REST_WP: state_d = S_REST_PC;
                S_REST_PC: state_d = S_REST_ST;
                default:   state_d = S_IDLE;
            endcase
        end
    end

    // hardware state updates
    always_comb begin
        upd = '0;
        if (launch && op == OP_SET_WP) begin
            upd.wp_we  = 1'b1;
            upd.val.wp = addr;
        end
        if (launch && op == OP_SET_PCST) begin
            upd.pc_we  = 1'b1;
            upd.st_we  = 1'b1;
            upd.val.pc = addr;
            upd.val.st = wdata;
        end
        if (accept && state_q == S_SAVE_ST) begin
            upd.wp_we  = 1'b1;
            upd.pc_we  = 1'b1;
            upd.val.wp = tmp_wp_q;
            upd.val.pc = tmp_pc_q;
        end
        if (accept && state_q == S_REST_ST) begin
            upd.wp_we  = 1'b1;
            upd.pc_we  = 1'b1;
            upd.st_we  = 1'b1;
            upd.val.wp = tmp_wp_q;
            upd.val.pc = tmp_pc_q;
            upd.val.st = mrdata;
        end
        if (accept && state_q == S_LINK) begin
            upd.pc_we  = 1'b1;
            upd.val.pc = addr_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            op_q     <= OP_NONE;
            idx_q    <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            tmp_wp_q <= '0;
            tmp_pc_q <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            state_q  <= state_d;
            rd_valid <= accept && (state_q == S_RD);
            if (launch) begin
                op_q   <= op;
                idx_q  <= idx;
                addr_q <= addr;
                data_q <= wdata;
            end
            if (accept && state_q == S_RD)
                rd_data <= mrdata;
            if (accept && (state_q == S_VEC_WP || state_q == S_REST_WP))
                tmp_wp_q <= mrdata;
            if (accept && (state_q == S_VEC_PC || state_q == S_REST_PC))
                tmp_pc_q <= mrdata;
        end
    end

    // independent count of reads accepted in the current call
    logic [1:0] call_reads_q;
    always_ff @(posedge clk) begin
        if (rst || launch)
            call_reads_q <= '0;
        else if (accept && !mcmd.we && op_q == OP_CALL && call_reads_q != 2'd3)
            call_reads_q <= call_reads_q + 2'd1;
    end

    // R5: every write of a call comes after both vector reads
    assert_vector_first_R5: assert property (@(posedge clk) disable iff (rst)
        (mcmd.req && mcmd.we && op_q == OP_CALL) |-> (call_reads_q == 2'd2));

    // R10: a stalled access is held unchanged
    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mcmd.req && !mready) |=> (mcmd.req && $stable(mcmd.addr) &&
                                   $stable(mcmd.we) && $stable(mcmd.wdata)));

    // R9: a start pulse while busy leaves the latched command alone
    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> ($stable(op_q) && $stable(addr_q) &&
                             $stable(data_q) && $stable(idx_q)));

endmodule

// File: rtl/wsp_ctx_engine.sv
module wsp_ctx_engine
    import wsp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_start,
    input  logic [2:0]  cmd_op,
    input  logic [3:0]  cmd_reg,
    input  logic [15:0] cmd_addr,
    input  logic [15:0] cmd_wdata,
    output logic        busy,
    output logic        rd_valid,
    output logic [15:0] rd_data,
    output logic [15:0] wp_o,
    output logic [15:0] pc_o,
    output logic [15:0] st_o,
    output logic        mem_req,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata,
    input  logic        mem_ready
);

    ctx_t     ctx;
    ctx_upd_t upd;
    mem_cmd_t mcmd;

    wsp_ctx_regs u_regs (
        .clk (clk),
        .rst (rst),
        .upd (upd),
        .ctx (ctx)
    );

    wsp_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (cmd_start),
        .op       (op_e'(cmd_op)),
        .idx      (ridx_t'(cmd_reg)),
        .addr     (cmd_addr),
        .wdata    (cmd_wdata),
        .ctx      (ctx),
        .mcmd     (mcmd),
        .mready   (mem_ready),
        .mrdata   (mem_rdata),
        .busy     (busy),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .upd      (upd)
    );

    assign wp_o      = ctx.wp;
    assign pc_o      = ctx.pc;
    assign st_o      = ctx.st;
    assign mem_req   = mcmd.req;
    assign mem_we    = mcmd.we;
    assign mem_addr  = mcmd.addr;
    assign mem_wdata = mcmd.wdata;

    // R2: read data valid only after an accepted read
    assert_rd_after_read_R2: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(mem_req && mem_ready && !mem_we));

endmodule

// File: tb/sim_wsp_ctx_engine.sv
module sim_wsp_ctx_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_start = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [3:0]  cmd_reg = '0;
    logic [15:0] cmd_addr = '0;
    logic [15:0] cmd_wdata = '0;
    logic        busy, rd_valid, mem_req, mem_we;
    logic [15:0] rd_data, wp_o, pc_o, st_o, mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready = 1'b1;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    wsp_ctx_engine u0 (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .cmd_reg(cmd_reg), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .wp_o(wp_o), .pc_o(pc_o), .st_o(st_o),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    // memory model: 1024 words, read data valid in the accepting cycle
    logic [15:0] mem [0:1023];
    assign mem_rdata = mem[mem_addr[10:1]];

    logic        log_we    [0:1023];
    logic [15:0] log_addr  [0:1023];
    logic [15:0] log_wdata [0:1023];
    int          log_n = 0;
    logic [15:0] last_rd = '0;
    int          rd_cnt = 0;
    logic        prev_stall = 1'b0;
    logic [15:0] prev_addr = '0, prev_wdata = '0;
    logic        prev_we = 1'b0;
    int          stall_seen = 0, stall_bad = 0;

    always @(posedge clk) begin
        if (!rst && mem_req && mem_ready) begin
            log_we[log_n & 1023]    = mem_we;
            log_addr[log_n & 1023]  = mem_addr;
            log_wdata[log_n & 1023] = mem_wdata;
            log_n = log_n + 1;
            if (mem_we) mem[mem_addr[10:1]] <= mem_wdata;
        end
        if (rd_valid) begin
            last_rd = rd_data;
            rd_cnt  = rd_cnt + 1;
        end
        if (prev_stall) begin
            stall_seen = stall_seen + 1;
            if (!mem_req || mem_addr != prev_addr || mem_we != prev_we || mem_wdata != prev_wdata)
                stall_bad = stall_bad + 1;
        end
        prev_stall = !rst && mem_req && !mem_ready;
        prev_addr  = mem_addr;
        prev_we    = mem_we;
        prev_wdata = mem_wdata;
    end

    logic       stall_mode = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready <= stall_mode ? lfsr[0] : 1'b1;
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [2:0] op, input logic [3:0] r,
                         input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        cmd_op = op; cmd_reg = r; cmd_addr = a; cmd_wdata = d;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic run(input logic [2:0] op, input logic [3:0] r,
                       input logic [15:0] a, input logic [15:0] d);
        pulse(op, r, a, d);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int base;
        logic [15:0] wps [3];
        logic [15:0] s_wp, s_pc, s_st;
        wps[0] = 16'h0000; wps[1] = 16'h0080; wps[2] = 16'h1FE0;
        for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 wp", wp_o, 16'h0); chk("R1 pc", pc_o, 16'h0);
        chk("R1 st", st_o, 16'h0); chk("R1 busy", {15'b0, busy}, 16'h0);
        chk("R1 req", {15'b0, mem_req}, 16'h0);

        // R11 / R2 / R3: sweep every register of three workspaces
        for (int w = 0; w < 3; w++) begin
            stall_mode = (w == 1);
            run(3'd5, 4'd0, wps[w], 16'h0);
            chk("R11 set wp", wp_o, wps[w]);
            for (int n = 0; n < 16; n++) begin
                base = log_n;
                run(3'd1, 4'(n), 16'h0, (16'h1111 * 16'(n)) ^ ~wps[w]);
                chk("R3 write count", 16'(log_n - base), 16'd1);
                chk("R3 write addr", log_addr[base & 1023], wps[w] + 16'(2 * n));
                chk("R3 write data", log_wdata[base & 1023], (16'h1111 * 16'(n)) ^ ~wps[w]);
            end
            for (int n = 0; n < 16; n++) begin
                base = log_n;
                run(3'd0, 4'(n), 16'h0, 16'h0);
                chk("R2 read addr", log_addr[base & 1023], wps[w] + 16'(2 * n));
                chk("R2 read we", {15'b0, log_we[base & 1023]}, 16'h0);
                chk("R2 read data", last_rd, (16'h1111 * 16'(n)) ^ ~wps[w]);
            end
        end

        // R4: wrap at the top of the address space
        run(3'd5, 4'd0, 16'hFFF0, 16'h0);
        base = log_n;
        run(3'd1, 4'd15, 16'h0, 16'hBEEF);
        chk("R4 wrap addr r15", log_addr[base & 1023], 16'h000E);
        base = log_n;
        run(3'd1, 4'd8, 16'h0, 16'hCAFE);
        chk("R4 wrap addr r8", log_addr[base & 1023], 16'h0000);
        run(3'd0, 4'd15, 16'h0, 16'h0);
        chk("R4 wrap read", last_rd, 16'hBEEF);

        // R5 / R6 / R9: call under stalls with a start pulse while busy
        stall_mode = 1'b1;
        run(3'd5, 4'd0, 16'h0100, 16'h0);
        run(3'd6, 4'd0, 16'h1234, 16'h00C3);
        chk("R11 set pc", pc_o, 16'h1234); chk("R11 set st", st_o, 16'h00C3);
        mem[16'h0040 >> 1] = 16'h0200;
        mem[16'h0042 >> 1] = 16'h3000;
        mem[16'h0100 >> 1] = 16'h5A5A;
        base = log_n;
        pulse(3'd2, 4'd0, 16'h0040, 16'h0);
        chk("R9 busy rises", {15'b0, busy}, 16'h1);
        pulse(3'd1, 4'd0, 16'h0, 16'hDEAD);
        while (busy) @(negedge clk);
        @(negedge clk);
        chk("R9 access count", 16'(log_n - base), 16'd5);
        chk("R9 ignored write", mem[16'h0100 >> 1], 16'h5A5A);
        chk("R5 vec0 addr", log_addr[base & 1023], 16'h0040);
        chk("R5 vec1 addr", log_addr[(base + 1) & 1023], 16'h0042);
        chk("R5 reads first", {14'b0, log_we[base & 1023], log_we[(base + 1) & 1023]}, 16'h0);
        chk("R6 save wp addr", log_addr[(base + 2) & 1023], 16'h021A);
        chk("R6 save pc addr", log_addr[(base + 3) & 1023], 16'h021C);
        chk("R6 save st addr", log_addr[(base + 4) & 1023], 16'h021E);
        chk("R6 save wp data", log_wdata[(base + 2) & 1023], 16'h0100);
        chk("R6 save pc data", log_wdata[(base + 3) & 1023], 16'h1234);
        chk("R6 save st data", log_wdata[(base + 4) & 1023], 16'h00C3);
        chk("R6 new wp", wp_o, 16'h0200); chk("R6 new pc", pc_o, 16'h3000);
        chk("R6 st kept", st_o, 16'h00C3);

        // R7: return
        base = log_n;
        run(3'd3, 4'd0, 16'h0, 16'h0);
        chk("R7 count", 16'(log_n - base), 16'd3);
        chk("R7 addr13", log_addr[base & 1023], 16'h021A);
        chk("R7 addr14", log_addr[(base + 1) & 1023], 16'h021C);
        chk("R7 addr15", log_addr[(base + 2) & 1023], 16'h021E);
        chk("R7 no writes", {13'b0, log_we[base & 1023], log_we[(base + 1) & 1023],
                             log_we[(base + 2) & 1023]}, 16'h0);
        chk("R7 wp", wp_o, 16'h0100); chk("R7 pc", pc_o, 16'h1234); chk("R7 st", st_o, 16'h00C3);

        // R8: link
        base = log_n;
        run(3'd4, 4'd0, 16'h5678, 16'h0);
        chk("R8 count", 16'(log_n - base), 16'd1);
        chk("R8 addr", log_addr[base & 1023], 16'h0116);
        chk("R8 data", log_wdata[base & 1023], 16'h1234);
        chk("R8 pc", pc_o, 16'h5678); chk("R8 wp", wp_o, 16'h0100);

        // R6: vector overlapping the new workspace
        run(3'd5, 4'd0, 16'h0400, 16'h0);
        run(3'd6, 4'd0, 16'h0AAA, 16'h0055);
        mem[16'h0300 >> 1] = 16'h02E6;
        mem[16'h0302 >> 1] = 16'h4444;
        run(3'd2, 4'd0, 16'h0300, 16'h0);
        chk("R6 overlap wp", wp_o, 16'h02E6); chk("R6 overlap pc", pc_o, 16'h4444);
        chk("R6 overlap r13", mem[16'h0300 >> 1], 16'h0400);
        chk("R6 overlap r14", mem[16'h0302 >> 1], 16'h0AAA);
        chk("R6 overlap r15", mem[16'h0304 >> 1], 16'h0055);

        // R12: opcode 7
        s_wp = wp_o; s_pc = pc_o; s_st = st_o;
        base = log_n;
        pulse(3'd7, 4'd3, 16'h1111, 16'h2222);
        chk("R12 busy", {15'b0, busy}, 16'h0);
        @(negedge clk);
        chk("R12 count", 16'(log_n - base), 16'd0);
        chk("R12 wp", wp_o, s_wp); chk("R12 pc", pc_o, s_pc); chk("R12 st", st_o, s_st);

        // R10: stalls were seen and held
        chk("R10 stalls seen", {15'b0, stall_seen > 0}, 16'h1);
        chk("R10 stall hold", 16'(stall_bad), 16'h0);

        // R1: reset in the middle of a call
        pulse(3'd2, 4'd0, 16'h0040, 16'h0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 mid wp", wp_o, 16'h0); chk("R1 mid pc", pc_o, 16'h0);
        chk("R1 mid st", st_o, 16'h0); chk("R1 mid busy", {15'b0, busy}, 16'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule